// File: doc/BRIEF.md
# Single-to-Half Float Converter

This block turns one binary32 floating-point operand into a binary16 value and, alongside the result, produces the exception flags of that conversion. A control byte given with each operand picks the rounding direction, or it hands that choice to an externally held global rounding mode. Results below the normal half range always come out as half subnormals. The flush-to-zero input has no effect on the result. A denormals-are-zero input makes binary32 subnormal operands act as signed zeros.

The converter is a single registered stage. An operand presented with `valid_i` high yields its result and flags on the next clock edge, with `valid_o` high. A new operand may be presented in every cycle. Trapping, instruction decode and packing of several lanes are left to the surrounding logic. The mask inputs are given so that the flag outputs can be read next to the mask state that those outer layers act on.

Top module: `f2h_cvt`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous cycle, and `res_o`/`flags_o` belong to that operand; while reset is asserted, `valid_o`, `res_o` and `flags_o` are all zero.
- R2: A finite operand whose value is exactly representable as a normal half is converted exactly with no flag raised; `flags_o` bit 0 is invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow, bit 4 precision.
- R3: When `ctrl_i[2]` is 0, `ctrl_i[1:0]` selects the rounding: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R4: When `ctrl_i[2]` is 1, `glob_rm_i` (same encoding) selects the rounding and `ctrl_i[1:0]` has no effect; `ctrl_i[7:3]` never affects any output.
- R5: Values below 2^-14 are rounded to half subnormals (exponent field 0), never flushed, and `ftz_i` has no effect on any output.
- R6: Underflow is raised when the exact value is below 2^-14 and is either inexact or `um_mask_i` is 0.
- R7: With `daz_i` 0, a binary32 subnormal operand raises denormal, and its rounded tiny result also raises underflow and precision, so that with the denormal mask set and the precision or underflow mask clear all three flags are raised; with `daz_i` 1 it gives a signed zero and no flags.
- R8: When the rounded magnitude exceeds 65504, overflow and precision are raised and the result is infinity when rounding moves away from zero for that sign (nearest-even, or directed toward that sign's infinity), else 0x7BFF with the sign kept.
- R9: Precision is raised whenever nonzero bits are discarded by rounding.
- R10: A signalling NaN (mantissa bit 22 clear) gives sign, exponent 0x1F, mantissa bit 9 set and bits [8:0] equal to operand bits [21:13], and raises invalid; a quiet NaN is passed through the same way without invalid.
- R11: Infinities and zeros map to half infinities and zeros of the same sign with no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present |
| op_i | input | 32 | binary32 operand |
| ctrl_i | input | 8 | Rounding control byte |
| glob_rm_i | input | 2 | Global rounding mode |
| um_mask_i | input | 1 | Underflow mask (1 = masked) |
| pm_mask_i | input | 1 | Precision mask (1 = masked) |
| dm_mask_i | input | 1 | Denormal mask (1 = masked) |
| daz_i | input | 1 | Treat binary32 subnormal operands as zero |
| ftz_i | input | 1 | Flush-to-zero request, ignored |
| valid_o | output | 1 | Result present |
| res_o | output | 16 | binary16 result |
| flags_o | output | 5 | Exception flags |

## Verification
Every result and flag vector is due exactly one clock edge after the operand is presented, because the only register on the path is the output stage. The driver places each operand on a falling edge and queues its expected value. The monitor pops one entry on every later falling edge where `valid_o` is high, so each comparison samples half a cycle after the capturing edge. Back-to-back operands and idle gaps are both used. This way a result that arrives too early, too late or out of order shows up as a mismatch against the queue.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int SP_EXP  = 8;
  localparam int SP_MAN  = 23;
  localparam int HP_EXP  = 5;
  localparam int HP_MAN  = 10;
  localparam int SP_W    = 1 + SP_EXP + SP_MAN;
  localparam int HP_W    = 1 + HP_EXP + HP_MAN;
  localparam int SP_BIAS = (1 << (SP_EXP - 1)) - 1;
  localparam int HP_BIAS = (1 << (HP_EXP - 1)) - 1;
  localparam int CALC_W  = SP_EXP + 2;
  localparam int FLAG_W  = 5;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rm_e;

  typedef enum logic [2:0] {
    CLS_FIN,
    CLS_ZERO,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } cls_e;

  // bit order is the external flag encoding
  typedef struct packed {
    logic prc;
    logic unf;
    logic ovf;
    logic den;
    logic inv;
  } flags_t;
endpackage

// File: rtl/f2h_unpack.sv
module f2h_unpack
  import f2h_pkg::*;
(
  input  logic                     [SP_W-1:0]   op_i,
  input  logic                                  daz_i,
  output logic                                  sign_o,
  output cls_e                                  cls_o,
  output logic                                  sub_o,
  output logic signed              [CALC_W-1:0] hexp_o,
  output logic                     [SP_MAN:0]   sig_o,
  output logic                     [HP_MAN-2:0] pay_o
);
  localparam logic signed [CALC_W-1:0] BIAS_DIFF = CALC_W'(SP_BIAS - HP_BIAS);

  logic [SP_EXP-1:0] exp_f;
  logic [SP_MAN-1:0] man_f;
  logic              e_zero, e_ones, m_nz;
  logic [SP_EXP-1:0] exp_eff;

  assign sign_o = op_i[SP_W-1];
  assign exp_f  = op_i[SP_MAN +: SP_EXP];
  assign man_f  = op_i[SP_MAN-1:0];
  assign e_zero = (exp_f == '0);
  assign e_ones = &exp_f;
  assign m_nz   = |man_f;

  always_comb begin
    cls_o = CLS_FIN;
    sub_o = 1'b0;
    if (e_ones) begin
      if (!m_nz)                cls_o = CLS_INF;
      else if (man_f[SP_MAN-1]) cls_o = CLS_QNAN;
      else                      cls_o = CLS_SNAN;
    end else if (e_zero && (!m_nz || daz_i)) begin
      cls_o = CLS_ZERO;
    end else begin
      sub_o = e_zero;
    end
  end

  // subnormal operands share the scale of exponent field 1
  assign exp_eff = e_zero ? SP_EXP'(1) : exp_f;
  assign hexp_o  = $signed({{(CALC_W-SP_EXP){1'b0}}, exp_eff}) - BIAS_DIFF;
  assign sig_o   = {~e_zero, man_f};
  assign pay_o   = man_f[SP_MAN-2 -: (HP_MAN-1)];
endmodule

// File: rtl/f2h_round.sv
module f2h_round
  import f2h_pkg::*;
(
  input  logic                               sign_i,
  input  logic signed        [CALC_W-1:0]    hexp_i,
  input  logic               [SP_MAN:0]      sig_i,
  input  rm_e                                rm_i,
  output logic               [HP_W-2:0]      mag_o,
  output logic                               inexact_o,
  output logic                               ovf_o,
  output logic                               tiny_o
);
  localparam int SH_BASE = SP_MAN - HP_MAN;
  localparam int SH_MAX  = SP_MAN + 2;
  localparam int SH_W    = $clog2(SH_MAX + 1);
  localparam int PAD     = SP_MAN + 3;
  localparam int WIDE_W  = SP_MAN + 1 + PAD;
  localparam int EXP_TOP = (1 << HP_EXP) - 1;
  localparam logic [HP_W-2:0] INF_MAG = {{HP_EXP{1'b1}}, {HP_MAN{1'b0}}};
  localparam logic [HP_W-2:0] MAX_FIN = {{(HP_EXP-1){1'b1}}, 1'b0, {HP_MAN{1'b1}}};

  logic signed [CALC_W-1:0] sh_full;
  logic [SH_W-1:0]          sh;
  logic [WIDE_W-1:0]        wide;
  logic [HP_MAN:0]          kept;
  logic                     guard, sticky, lsb, inc, norm, big, to_inf;
  logic [HP_W-2:0]          base, sum;
  logic                     unused_hi;

  assign norm = (hexp_i > 0);
  assign big  = (hexp_i >= CALC_W'(EXP_TOP));

  always_comb begin
    if (norm) sh_full = CALC_W'(SH_BASE);
    else      sh_full = CALC_W'(SH_BASE + 1) - hexp_i;
    if (sh_full > CALC_W'(SH_MAX)) sh = SH_W'(SH_MAX);
    else                           sh = sh_full[SH_W-1:0];
  end

  // one shifter serves normal and subnormal alignment
  assign wide      = {sig_i, {PAD{1'b0}}} >> sh;
  assign kept      = wide[PAD +: HP_MAN+1];
  assign guard     = wide[PAD-1];
  assign sticky    = |wide[PAD-2:0];
  assign lsb       = kept[0];
  assign unused_hi = ^wide[WIDE_W-1:PAD+HP_MAN+1];

  always_comb begin
    unique case (rm_i)
      RM_NEAR: inc = guard & (sticky | lsb);
      RM_DOWN: inc = sign_i & (guard | sticky);
      RM_UP:   inc = ~sign_i & (guard | sticky);
      default: inc = 1'b0;
    endcase
  end

  assign to_inf = (rm_i == RM_NEAR) || (rm_i == RM_UP && !sign_i) ||
                  (rm_i == RM_DOWN && sign_i);

  assign base = norm ? {hexp_i[HP_EXP-1:0], kept[HP_MAN-1:0]}
                     : {{HP_EXP{1'b0}}, kept[HP_MAN-1:0]};
  assign sum  = base + {{(HP_W-2){1'b0}}, inc};

  always_comb begin
    if (big) begin
      mag_o     = to_inf ? INF_MAG : MAX_FIN;
      ovf_o     = 1'b1;
      inexact_o = 1'b1;
    end else begin
      mag_o     = sum;
      ovf_o     = (sum == INF_MAG);
      inexact_o = guard | sticky;
    end
  end

  assign tiny_o = ~norm;
endmodule

// File: rtl/f2h_cvt.sv
module f2h_cvt
  import f2h_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] op_i,
  input  logic [7:0]  ctrl_i,
  input  logic [1:0]  glob_rm_i,
  input  logic        um_mask_i,
  input  logic        pm_mask_i,
  input  logic        dm_mask_i,
  input  logic        daz_i,
  input  logic        ftz_i,
  output logic        valid_o,
  output logic [15:0] res_o,
  output logic [4:0]  flags_o
);
  localparam logic [HP_W-2:0] INF_MAG = {{HP_EXP{1'b1}}, {HP_MAN{1'b0}}};

  logic                     sign;
  cls_e                     cls;
  logic                     sub_in;
  logic signed [CALC_W-1:0] hexp;
  logic [SP_MAN:0]          sig;
  logic [HP_MAN-2:0]        pay;
  rm_e                      rm;
  logic [HP_W-2:0]          mag;
  logic                     inexact, ovf, tiny;
  logic [HP_W-1:0]          res_d;
  flags_t                   flg_d;
  logic                     unused_in;

  // masks other than underflow only matter to outer trap logic
  assign unused_in = ^{ctrl_i[7:3], ftz_i, pm_mask_i, dm_mask_i};

  assign rm = rm_e'(ctrl_i[2] ? glob_rm_i : ctrl_i[1:0]);

  f2h_unpack u_unpack (
    .op_i   (op_i),
    .daz_i  (daz_i),
    .sign_o (sign),
    .cls_o  (cls),
    .sub_o  (sub_in),
    .hexp_o (hexp),
    .sig_o  (sig),
    .pay_o  (pay)
  );

  f2h_round u_round (
    .sign_i    (sign),
    .hexp_i    (hexp),
    .sig_i     (sig),
    .rm_i      (rm),
    .mag_o     (mag),
    .inexact_o (inexact),
    .ovf_o     (ovf),
    .tiny_o    (tiny)
  );

  always_comb begin
    flg_d = '0;
    unique case (cls)
      CLS_ZERO: res_d = {sign, {(HP_W-1){1'b0}}};
      CLS_INF:  res_d = {sign, INF_MAG};
      CLS_QNAN: res_d = {sign, {HP_EXP{1'b1}}, 1'b1, pay};
      CLS_SNAN: begin
        res_d     = {sign, {HP_EXP{1'b1}}, 1'b1, pay};
        flg_d.inv = 1'b1;
      end
      default: begin
        res_d     = {sign, mag};
        flg_d.ovf = ovf;
        flg_d.prc = inexact | ovf;
        flg_d.unf = tiny & (inexact | ~um_mask_i);
        flg_d.den = sub_in;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= res_d;
        flags_o <= flg_d;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_ovf_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o[2] |-> flags_o[4] &&
      (res_o[14:0] == 15'h7C00 || res_o[14:0] == 15'h7BFF));
  a_r6_unf_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o[3] |-> res_o[14:10] <= 5'd1);
  a_r7_den_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[30:23] == 8'd0 && op_i[22:0] != 23'd0 && !daz_i &&
      dm_mask_i && (!pm_mask_i || !um_mask_i)
      |=> flags_o[1] && flags_o[3] && flags_o[4]);
  a_r7_daz_no_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && daz_i |=> !flags_o[1]);
  a_r10_inv_is_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_o[0] |-> (&res_o[14:10]) && res_o[9]);
endmodule

// File: tb/f2h_cvt_tb_top.sv
module f2h_cvt_tb_top;
  typedef struct {
    logic [15:0] res;
    logic [4:0]  flg;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_i = '0;
  logic [7:0]  ctrl_i = '0;
  logic [1:0]  glob_rm_i = '0;
  logic        um_mask_i = 1'b1;
  logic        pm_mask_i = 1'b0;
  logic        dm_mask_i = 1'b1;
  logic        daz_i = 1'b0;
  logic        ftz_i = 1'b0;
  logic        valid_o;
  logic [15:0] res_o;
  logic [4:0]  flags_o;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  f2h_cvt dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .ctrl_i    (ctrl_i),
    .glob_rm_i (glob_rm_i),
    .um_mask_i (um_mask_i),
    .pm_mask_i (pm_mask_i),
    .dm_mask_i (dm_mask_i),
    .daz_i     (daz_i),
    .ftz_i     (ftz_i),
    .valid_o   (valid_o),
    .res_o     (res_o),
    .flags_o   (flags_o)
  );

  task automatic drv(input logic [31:0] op, input logic [7:0] ctrl,
                     input logic [1:0] grm, input logic um, input logic daz,
                     input logic ftz, input logic [15:0] er,
                     input logic [4:0] ef, input string tag);
    exp_t e;
    @(negedge clk);
    op_i = op; ctrl_i = ctrl; glob_rm_i = grm; um_mask_i = um;
    daz_i = daz; ftz_i = ftz; valid_i = 1'b1;
    e.res = er; e.flg = ef; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      op_i = 32'hDEAD_BEEF;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: result due one edge after the operand
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result res=%h flags=%h expected none", res_o, flags_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (res_o !== e.res || flags_o !== e.flg) begin
          errors++;
          $display("FAIL %s res=%h flags=%h expected res=%h flags=%h",
                   e.tag, res_o, flags_o, e.res, e.flg);
        end
      end
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=drained queue");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || res_o !== 16'h0 || flags_o !== 5'h0) begin
      errors++;
      $display("FAIL R1 reset state v=%b res=%h flags=%h expected 0 0000 00",
               valid_o, res_o, flags_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2 exact normals
    drv(32'h3F80_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h3C00, 5'h00, "R2 one");
    drv(32'hC020_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'hC100, 5'h00, "R2 neg");
    drv(32'h477F_E000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h7BFF, 5'h00, "R2 max");
    drv(32'h3880_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0400, 5'h00, "R2 minnorm");
    idle(1);
    // R3 / R9 rounding modes
    drv(32'h3F80_1000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h3C00, 5'h10, "R3 tie even");
    drv(32'h3F80_1000, 8'h02, 2'd0, 1'b1, 1'b0, 1'b0, 16'h3C01, 5'h10, "R3 up");
    drv(32'h3F80_1000, 8'h03, 2'd0, 1'b1, 1'b0, 1'b0, 16'h3C00, 5'h10, "R3 trunc");
    drv(32'h3F80_3000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h3C02, 5'h10, "R3 tie odd");
    drv(32'hBF80_0800, 8'h01, 2'd0, 1'b1, 1'b0, 1'b0, 16'hBC01, 5'h10, "R3 down neg");
    drv(32'hBF80_0800, 8'h02, 2'd0, 1'b1, 1'b0, 1'b0, 16'hBC00, 5'h10, "R3 up neg");
    drv(32'hBF80_0800, 8'h03, 2'd0, 1'b1, 1'b0, 1'b0, 16'hBC00, 5'h10, "R9 trunc neg");
    // R4 global mode and ignored bits
    drv(32'h3F80_0800, 8'h04, 2'd2, 1'b1, 1'b0, 1'b0, 16'h3C01, 5'h10, "R4 global up");
    drv(32'h3F80_0800, 8'h07, 2'd2, 1'b1, 1'b0, 1'b0, 16'h3C01, 5'h10, "R4 low bits ignored");
    drv(32'h3F80_0800, 8'h06, 2'd0, 1'b1, 1'b0, 1'b0, 16'h3C00, 5'h10, "R4 global near");
    drv(32'h3F80_0800, 8'hFA, 2'd0, 1'b1, 1'b0, 1'b0, 16'h3C01, 5'h10, "R4 upper bits up");
    drv(32'h3F80_0800, 8'hF8, 2'd2, 1'b1, 1'b0, 1'b0, 16'h3C00, 5'h10, "R4 upper bits near");
    idle(2);
    // R8 overflow
    drv(32'h4780_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h7C00, 5'h14, "R8 near inf");
    drv(32'h4780_0000, 8'h03, 2'd0, 1'b1, 1'b0, 1'b0, 16'h7BFF, 5'h14, "R8 trunc max");
    drv(32'hC780_0000, 8'h02, 2'd0, 1'b1, 1'b0, 1'b0, 16'hFBFF, 5'h14, "R8 neg up");
    drv(32'hC780_0000, 8'h01, 2'd0, 1'b1, 1'b0, 1'b0, 16'hFC00, 5'h14, "R8 neg down");
    drv(32'h477F_F000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h7C00, 5'h14, "R8 round carry");
    drv(32'h477F_F000, 8'h03, 2'd0, 1'b1, 1'b0, 1'b0, 16'h7BFF, 5'h10, "R9 no carry");
    // R5 / R6 tiny results
    drv(32'h3580_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0010, 5'h00, "R5 exact sub");
    drv(32'h3580_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, 16'h0010, 5'h00, "R5 ftz ignored");
    drv(32'h3380_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0001, 5'h00, "R5 min sub");
    drv(32'h3300_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 5'h18, "R5 half min sub");
    drv(32'h3300_0000, 8'h02, 2'd0, 1'b1, 1'b0, 1'b1, 16'h0001, 5'h18, "R5 up min sub");
    drv(32'h387F_E000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0400, 5'h18, "R6 sub to norm");
    drv(32'h3580_0000, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0010, 5'h08, "R6 unmasked exact");
    idle(1);
    // R7 subnormal operands
    drv(32'h0000_0001, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 5'h1A, "R7 den near");
    drv(32'h0000_0001, 8'h02, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0001, 5'h1A, "R7 den up");
    drv(32'h8040_0000, 8'h01, 2'd0, 1'b1, 1'b0, 1'b0, 16'h8001, 5'h1A, "R7 den neg down");
    drv(32'h0040_0000, 8'h02, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0000, 5'h00, "R7 daz");
    drv(32'h8040_0000, 8'h01, 2'd0, 1'b1, 1'b1, 1'b0, 16'h8000, 5'h00, "R7 daz neg");
    // R10 NaN, R11 specials
    drv(32'h7F81_2345, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h7E09, 5'h01, "R10 snan");
    drv(32'hFF80_0001, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'hFE00, 5'h01, "R10 snan neg");
    drv(32'hFFC0_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'hFE00, 5'h00, "R10 qnan");
    drv(32'h7F80_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h7C00, 5'h00, "R11 pinf");
    drv(32'hFF80_0000, 8'h03, 2'd0, 1'b1, 1'b0, 1'b0, 16'hFC00, 5'h00, "R11 ninf");
    drv(32'h8000_0000, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h8000, 5'h00, "R11 nzero");
    drv(32'h0000_0000, 8'h02, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 5'h00, "R11 pzero");
    idle(4);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R1 pending results actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule